// File: doc/BRIEF.md
# Read-Cycle-Only Host to 8-bit ISA I/O Bridge

This block sits between a host expansion port that can only perform read cycles and an 8-bit ISA-style peripheral's I/O register file. Two externally decoded select strobes tell it which window the host is touching. One is the read window, normally mapped at 0xFA0000. The other is the write window, 64 KiB higher at 0xFB0000. Host address bits A13..A9 select one of 32 ISA register ports, spaced 512 bytes apart in host space. A host read in the read window becomes an ISA I/O read, and the captured byte is returned on the host data bus. A host read in the write window becomes an ISA I/O write. The byte written is carried on host address bits A8..A1, since the port has no A0 and no write strobe.

The bridge only sequences single byte accesses. It has no interrupt path, so software polls the controller on a periodic tick. Block moves are repeated accesses to one port address, one byte per host cycle, and the bridge never increments the address itself. The control is a five-state machine:
- **IDLE**: waits for a select.
- **SETUP**: one cycle in which the port address, and for writes the data, are driven with the strobe still off.
- **STROBE**: IOR or IOW is held low for `STROBE_CYC` cycles.
- **HOLD**: one cycle with the strobe released and address and data still held.
- **DONE**: the host is released and the block waits for the select to drop.

The transitions are:
- IDLE→SETUP on any select.
- SETUP→STROBE always.
- STROBE→HOLD when the pulse timer expires.
- HOLD→DONE always.
- DONE→IDLE once both selects are low.

Top module: `isa_rdonly_bridge`

## Requirements
- R1: A host cycle with only the read-window select high produces exactly one ISA read: `isa_ior_n` goes low, `isa_iow_n` stays high, and `isa_sa` equals host address bits [13:9].
- R2: A host cycle with the write-window select high produces exactly one ISA write. `isa_iow_n` goes low, `isa_ior_n` stays high, `isa_sa` equals host address bits [13:9], `isa_d_o` equals host address bits [8:1], and `isa_d_oe` is high.
- R3: When both selects are high together, the cycle is treated as a write.
- R4: The active ISA strobe stays low for exactly `STROBE_CYC` clock cycles (default 4).
- R5: `isa_sa`, and for writes `isa_d_o` with `isa_d_oe` high, are valid one cycle before the strobe falls, and stay unchanged until one cycle after it rises.
- R6: For a read, the ISA data present in the last cycle of the IOR pulse is latched and presented on `host_d` until the select drops. Later changes of `isa_d_i` do not alter it.
- R7: During a write-window cycle, `host_d` reads 0x00 once the host is released.
- R8: `host_wait` is high from the cycle a select rises until the HOLD cycle ends. It falls `STROBE_CYC`+3 clock edges after the select is first seen.
- R9: Holding a select high after completion starts no further ISA cycle. A new cycle starts only after the select is released and raised again. Repeated accesses to one port keep the same `isa_sa`.
- R10: After reset, both ISA strobes are high and `isa_d_oe` is low until the first decoded access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd_sel | input | 1 | Read-window select, active high |
| host_wr_sel | input | 1 | Write-window select, active high |
| host_addr | input | 13 | Host address bits A13..A1 |
| host_d | output | 8 | Data returned to the host |
| host_wait | output | 1 | Wait request to the host, high while the ISA cycle runs |
| isa_sa | output | 5 | ISA port address |
| isa_ior_n | output | 1 | ISA I/O read strobe, active low |
| isa_iow_n | output | 1 | ISA I/O write strobe, active low |
| isa_d_o | output | 8 | ISA write data |
| isa_d_oe | output | 1 | ISA data output enable |
| isa_d_i | input | 8 | ISA read data |

## Verification
The bench drives port addresses 0 and 31 and data bytes 0x00, 0xFF and mixed patterns. A decode slip at the bit boundary would then show up as a wrong port or a shifted byte. It holds selects high long after completion, which catches a design that restarts on a level rather than on a fresh select and so issues duplicate ISA writes. It changes the ISA data after the pulse to catch a transparent read path, and raises both selects at once to catch a design that treats the cycle as a read. Each strobe is timed and its surrounding setup and hold cycles are inspected, so a pulse that is one cycle short or an address that changes at the strobe edge is reported.

// File: rtl/isa_brg_pkg.sv
package isa_brg_pkg;

    typedef enum logic {
        XFER_RD = 1'b0,
        XFER_WR = 1'b1
    } xfer_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_DONE   = 3'd4
    } brg_state_e;

endpackage

// File: rtl/isa_brg_decode.sv
module isa_brg_decode
    import isa_brg_pkg::*;
#(
    parameter int SA_W   = 5,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic                     rd_sel,
    input  logic                     wr_sel,
    input  logic [SA_W+DATA_W:1]     addr,
    output logic [SA_W-1:0]          sa,
    output logic [DATA_W-1:0]        wdata,
    output xfer_kind_e               kind
);
    localparam int TOP = SA_W + DATA_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sa    <= '0;
            wdata <= '0;
            kind  <= XFER_RD;
        end else if (capture) begin
            sa    <= addr[TOP:DATA_W+1];
            wdata <= addr[DATA_W:1];
            kind  <= wr_sel ? XFER_WR : XFER_RD;
        end
    end

    // R3
    isa_brg_dec_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && wr_sel) |=> (kind == XFER_WR));

    // R1
    isa_brg_dec_rdkind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && rd_sel && !wr_sel) |=> (kind == XFER_RD));

endmodule

// File: rtl/isa_brg_timer.sv
module isa_brg_timer #(
    parameter int PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (PULSE < 2) ? 1 : $clog2(PULSE);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R4
    isa_brg_tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == LOAD_VAL));

endmodule

// File: rtl/isa_rdonly_bridge.sv
module isa_rdonly_bridge
    import isa_brg_pkg::*;
#(
    parameter int SA_W       = 5,
    parameter int DATA_W     = 8,
    parameter int STROBE_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_rd_sel,
    input  logic                   host_wr_sel,
    input  logic [SA_W+DATA_W:1]   host_addr,
    output logic [DATA_W-1:0]      host_d,
    output logic                   host_wait,
    output logic [SA_W-1:0]        isa_sa,
    output logic                   isa_ior_n,
    output logic                   isa_iow_n,
    output logic [DATA_W-1:0]      isa_d_o,
    output logic                   isa_d_oe,
    input  logic [DATA_W-1:0]      isa_d_i
);
    localparam int LEN_W = $clog2(STROBE_CYC + 2);

    brg_state_e        state, state_nx;
    xfer_kind_e        kind;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_byte;
    logic              any_sel;
    logic              start;
    logic              tmr_exp;

    assign any_sel = host_rd_sel | host_wr_sel;
    assign start   = (state == ST_IDLE) && any_sel;

    isa_brg_decode #(.SA_W(SA_W), .DATA_W(DATA_W)) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (start),
        .rd_sel  (host_rd_sel),
        .wr_sel  (host_wr_sel),
        .addr    (host_addr),
        .sa      (isa_sa),
        .wdata   (wdata),
        .kind    (kind)
    );

    isa_brg_timer #(.PULSE(STROBE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state == ST_SETUP),
        .run     (state == ST_STROBE),
        .expired (tmr_exp)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (any_sel) state_nx = ST_SETUP;
            ST_SETUP:  state_nx = ST_STROBE;
            ST_STROBE: if (tmr_exp) state_nx = ST_HOLD;
            ST_HOLD:   state_nx = ST_DONE;
            ST_DONE:   if (!any_sel) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_byte <= '0;
        end else if (state == ST_STROBE && tmr_exp && kind == XFER_RD) begin
            rd_byte <= isa_d_i;
        end
    end

    always_comb begin
        isa_ior_n = 1'b1;
        isa_iow_n = 1'b1;
        isa_d_oe  = 1'b0;
        isa_d_o   = wdata;
        host_wait = 1'b0;
        host_d    = '0;
        unique case (state)
            ST_IDLE: begin
                host_wait = any_sel;
            end
            ST_SETUP, ST_HOLD: begin
                host_wait = 1'b1;
                isa_d_oe  = (kind == XFER_WR);
            end
            ST_STROBE: begin
                host_wait = 1'b1;
                isa_d_oe  = (kind == XFER_WR);
                isa_ior_n = (kind == XFER_WR);
                isa_iow_n = (kind == XFER_RD);
            end
            ST_DONE: begin
                host_d = (kind == XFER_RD) ? rd_byte : '0;
            end
            default: ;
        endcase
    end

    // strobe-width counter used only by the checks below
    logic [LEN_W-1:0] low_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len <= '0;
        end else if (!isa_ior_n || !isa_iow_n) begin
            low_len <= low_len + 1'b1;
        end else begin
            low_len <= '0;
        end
    end

    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!isa_ior_n && !isa_iow_n));

    // R4
    ior_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isa_ior_n) |-> (low_len == LEN_W'(STROBE_CYC)));

    // R4
    iow_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isa_iow_n) |-> (low_len == LEN_W'(STROBE_CYC)));

    // R5
    sa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE || state == ST_HOLD) |-> $stable(isa_sa));

    // R5
    wdata_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(isa_iow_n) |-> $past(isa_d_oe));

    // R5
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isa_iow_n) |-> (isa_d_oe && $stable(isa_d_o)));

    // R8
    wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_sel && !host_wait) |-> (isa_ior_n && isa_iow_n));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && any_sel) |=> (state == ST_DONE));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(state) == ST_DONE) |-> $stable(host_d));

endmodule

// File: tb/isa_rdonly_bridge_bench.sv
module isa_rdonly_bridge_bench;
    localparam int SA_W = 5;
    localparam int DW   = 8;
    localparam int N    = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rd_sel = 1'b0;
    logic            wr_sel = 1'b0;
    logic [13:1]     addr = '0;
    logic [DW-1:0]   host_d;
    logic            host_wait;
    logic [SA_W-1:0] isa_sa;
    logic            ior_n, iow_n;
    logic [DW-1:0]   isa_d_o;
    logic            isa_d_oe;
    logic [DW-1:0]   isa_d_i = '0;

    int tests = 0;
    int fails = 0;

    // expected item: {is_write, sa, data}
    logic [13:0] exp_q[$];

    always #10 clk = ~clk;

    isa_rdonly_bridge #(.SA_W(SA_W), .DATA_W(DW), .STROBE_CYC(N)) u_isa_rdonly_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_rd_sel(rd_sel), .host_wr_sel(wr_sel), .host_addr(addr),
        .host_d(host_d), .host_wait(host_wait),
        .isa_sa(isa_sa), .isa_ior_n(ior_n), .isa_iow_n(iow_n),
        .isa_d_o(isa_d_o), .isa_d_oe(isa_d_oe), .isa_d_i(isa_d_i)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: runs at negedge, pops scoreboard on each strobe release
    logic            p_ior = 1'b1, p_iow = 1'b1, p_oe = 1'b0;
    logic [SA_W-1:0] p_sa = '0;
    logic [DW-1:0]   p_do = '0;
    logic [SA_W-1:0] c_sa = '0;
    logic [DW-1:0]   c_do = '0;
    logic            c_wr = 1'b0;
    int              width = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((p_ior && !ior_n) || (p_iow && !iow_n)) begin
                c_wr  = !iow_n;
                c_sa  = isa_sa;
                c_do  = isa_d_o;
                width = 0;
                check("R5", "sa setup", {11'd0, p_sa}, {11'd0, isa_sa});
                if (c_wr) begin
                    check("R5", "data setup oe", {15'd0, p_oe}, 16'd1);
                    check("R5", "data setup value", {8'd0, p_do}, {8'd0, isa_d_o});
                end
            end
            if (!ior_n || !iow_n) width++;
            if ((!p_ior && ior_n) || (!p_iow && iow_n)) begin
                check("R4", "strobe width", 16'(width), 16'(N));
                check("R5", "sa hold", {11'd0, isa_sa}, {11'd0, c_sa});
                if (c_wr) begin
                    check("R5", "data hold", {7'd0, isa_d_oe, isa_d_o}, {7'd0, 1'b1, c_do});
                end
                if (exp_q.size() == 0) begin
                    check("R9", "unexpected ISA cycle", 16'd1, 16'd0);
                end else begin
                    logic [13:0] e;
                    e = exp_q.pop_front();
                    check(e[13] ? "R2" : "R1", "kind", {15'd0, c_wr}, {15'd0, e[13]});
                    check(e[13] ? "R2" : "R1", "port", {11'd0, c_sa}, {11'd0, e[12:8]});
                    if (e[13]) check("R2", "write byte", {8'd0, c_do}, {8'd0, e[7:0]});
                end
            end
            p_ior = ior_n; p_iow = iow_n; p_oe = isa_d_oe;
            p_sa = isa_sa; p_do = isa_d_o;
        end
    end

    // driver: one host access; kind 0 read, 1 write, 2 both selects
    task automatic access(input int kind, input logic [4:0] port,
                          input logic [7:0] val, input int linger);
        int cyc = 0;
        @(negedge clk);
        addr   = {port, (kind == 0) ? 8'h00 : val};
        isa_d_i = val;
        exp_q.push_back({(kind != 0), port, val});
        rd_sel = (kind != 1);
        wr_sel = (kind != 0);
        #1;
        check("R8", "wait on select", {15'd0, host_wait}, 16'd1);
        while (host_wait && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        check("R8", "wait latency", 16'(cyc), 16'(N + 3));
        if (kind == 0) begin
            check("R6", "read byte", {8'd0, host_d}, {8'd0, val});
            isa_d_i = ~val;
        end else begin
            check("R7", "write host data", {8'd0, host_d}, 16'h0);
        end
        for (int i = 0; i < linger; i++) begin
            @(negedge clk);
            check("R9", "no restrobe", {14'd0, ior_n, iow_n}, 16'h3);
        end
        if (kind == 0 && linger > 0)
            check("R6", "read byte held", {8'd0, host_d}, {8'd0, val});
        rd_sel = 1'b0;
        wr_sel = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10
        check("R10", "strobes idle", {14'd0, ior_n, iow_n}, 16'h3);
        check("R10", "oe idle", {15'd0, isa_d_oe}, 16'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "strobes after reset", {13'd0, ior_n, iow_n, isa_d_oe}, 16'h6);

        access(0, 5'd0,  8'hA5, 0);     // R1
        access(0, 5'd31, 8'hFF, 4);     // R1, R6, R9
        access(1, 5'd31, 8'h00, 0);     // R2
        access(1, 5'd0,  8'hFF, 3);     // R2, R9
        access(1, 5'd10, 8'h5A, 0);     // R2 mixed
        access(2, 5'd7,  8'h3C, 0);     // R3
        // R9 block transfer: same port, fresh select each byte
        for (int b = 0; b < 4; b++) access(1, 5'd16, 8'(8'h11 * b), 0);
        for (int b = 0; b < 3; b++) access(0, 5'd16, 8'(8'h80 + b), 1);

        repeat (10) @(negedge clk);
        check("R9", "scoreboard empty", 16'(exp_q.size()), 16'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule